// File: doc/BRIEF.md
# Microwire Serial EEPROM Master

This block drives a three-wire serial EEPROM that stores 16-bit words and uses an active-high chip select. The host starts a request by pulsing `start_i` with a direction, a word offset and a word count. The block first checks the request against the device size. A request that fails the check is rejected with an error pulse, and the serial pins are never touched.

A read sends a separate command frame for every word. The frame carries the read opcode and the plain word address. The block then shifts in the 16-bit word and returns the device to standby. A write brackets its words with an enable instruction before the first word and a disable instruction after the last one. For every word the block sends the opcode, the address and the data, returns to standby, and polls the device output until it reports ready. Write data is streamed: the block pulses `wr_take_o` when it has taken the word on `wr_data_i`. Read words appear on `rd_data_o` with a single-cycle `rd_valid_o`.

Each pin change is held for `DLY` system clocks. The pause between ready polls is set by `poll_gap_i`.

Top module: `mw_eeprom_master`

## Requirements
- R1: A request is rejected when the offset is at or beyond 2^ADDR_W, when the count is zero, or when the count is larger than 2^ADDR_W minus the offset. A rejected request gives `err_o` one cycle after `start_i`, and chip select never rises.
- R2: A read sends, for every word, the start-and-opcode bits 110 and then the ADDR_W-bit word address (not doubled), all MSB first. It then clocks in 16 bits MSB first, sampled while SK is high. The word is delivered on `rd_data_o` with `rd_valid_o`, and no byte swap is done.
- R3: Every word uses its own chip-select cycle. A read of N words raises chip select N+1 times, and a write of N words raises it 2N+2 times.
- R4: Before the first word of a write, the block sends the 5-bit enable code 10011 followed by ADDR_W-2 zero bits, and then goes to standby.
- R5: A write sends, for every word, the bits 101, the ADDR_W-bit address and the 16 data bits MSB first. It pulses `wr_take_o` once per word taken.
- R6: After each written word, no further command starts until the device output reads high (ready). Polls are at least `poll_gap_i`+1 clocks apart.
- R7: If POLL_MAX polls in a row read low, the block gives up. It drives chip select low, sends no disable code and pulses `err_o`, not `done_o`.
- R8: After the last written word, the block sends the disable code 10000 followed by ADDR_W-2 zero bits.
- R9: Every accepted request ends with chip select and DI driven low and one SK pulse. Chip select stays low while the block is idle.
- R10: `done_o` and `err_o` are single-cycle pulses and are never high together.
- R11: DI never changes while SK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, honoured only while idle |
| write_i | input | 1 | 1 = write request, 0 = read request |
| offset_i | input | HOST_W | First word address |
| count_i | input | HOST_W | Number of words |
| poll_gap_i | input | GAP_W | Extra clocks between ready polls |
| wr_data_i | input | 16 | Next word to write |
| wr_take_o | output | 1 | Pulse: `wr_data_i` was taken |
| rd_data_o | output | 16 | Last word read |
| rd_valid_o | output | 1 | Pulse: `rd_data_o` holds a new word |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | Pulse: request completed |
| err_o | output | 1 | Pulse: request rejected or write timed out |
| ee_cs_o | output | 1 | Device chip select, active high |
| ee_sk_o | output | 1 | Device serial clock |
| ee_di_o | output | 1 | Serial data to the device |
| ee_do_i | input | 1 | Serial data / ready from the device |

## Verification
The assertions assume three things about the inputs. `start_i` matters only in the idle state. `poll_gap_i` and `wr_data_i` stay steady between a take pulse and the next command frame. `ee_do_i` changes only on clock edges, in step with the device's view of SK. The bench changes the request and gap inputs only between requests and replaces the write word right after each take pulse. Its device model updates its output through a register on the clock edge after it sees SK rise. That leaves a full `DLY` window before the block samples.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
    // elementary pin sequences run by the wire engine
    typedef enum logic [2:0] {
        OP_PREP, OP_OUT, OP_IN, OP_STBY, OP_STOP
    } wire_op_e;

    // request sequencer states
    typedef enum logic [3:0] {
        S_IDLE, S_PREP, S_EWEN, S_EN_SB, S_CMD, S_RDIN, S_RD_SB,
        S_WR_SB, S_POLL, S_GAP, S_WR_SB2, S_EWDS, S_STOP
    } seq_e;
endpackage

// File: rtl/mw_bounds.sv
`timescale 1ns/1ps
module mw_bounds #(
    parameter int ADDR_W = 6,
    parameter int HOST_W = 16
) (
    input  logic [HOST_W-1:0] offset_i,
    input  logic [HOST_W-1:0] count_i,
    output logic              ok_o
);
    localparam logic [HOST_W:0] SIZE = (HOST_W+1)'(1) << ADDR_W;

    logic [HOST_W:0] ofs_x, cnt_x, room;

    always_comb begin
        ofs_x = {1'b0, offset_i};
        cnt_x = {1'b0, count_i};
        room  = SIZE - ofs_x;
        ok_o  = (count_i != '0) && (ofs_x < SIZE) && (cnt_x <= room);
    end
endmodule

// File: rtl/mw_wire.sv
`timescale 1ns/1ps
module mw_wire
    import mw_pkg::*;
#(
    parameter int SH_W   = 25,
    parameter int DLY    = 4,
    parameter int WORD_W = 16,
    parameter int NB_W   = $clog2(SH_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  wire_op_e          op_i,
    input  logic [SH_W-1:0]   vec_i,
    input  logic [NB_W-1:0]   nbits_i,
    output logic              idle_o,
    output logic              fin_o,
    output logic [WORD_W-1:0] rx_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i
);
    localparam int DLY_W = $clog2(DLY + 1);

    typedef struct packed {
        logic              busy;
        wire_op_e          op;
        logic [1:0]        ph;
        logic [NB_W-1:0]   left;
        logic [DLY_W-1:0]  tmr;
        logic [SH_W-1:0]   sh;
        logic [WORD_W-1:0] rx;
        logic              cs;
        logic              sk;
        logic              di;
        logic              fin;
    } wire_st_t;

    wire_st_t q, n;

    always_comb begin
        n     = q;
        n.fin = 1'b0;
        if (!q.busy) begin
            if (go_i) begin
                n.busy = 1'b1;
                n.op   = op_i;
                n.ph   = 2'd0;
                n.tmr  = DLY_W'(DLY - 1);
                n.sh   = vec_i;
                n.left = nbits_i;
                case (op_i)
                    OP_PREP: begin n.sk = 1'b0; n.di = 1'b0; end
                    OP_OUT:  begin n.sk = 1'b0; n.di = vec_i[SH_W-1]; end
                    OP_IN:   begin n.sk = 1'b1; n.di = 1'b0; end
                    OP_STBY: begin n.cs = 1'b0; n.sk = 1'b0; end
                    default: begin n.cs = 1'b0; n.di = 1'b0; end
                endcase
            end
        end else if (q.tmr != '0) begin
            n.tmr = q.tmr - 1'b1;
        end else begin
            n.tmr = DLY_W'(DLY - 1);
            n.ph  = q.ph + 2'd1;
            case (q.op)
                OP_PREP: begin
                    if (q.ph == 2'd0) n.cs = 1'b1;
                    else begin n.busy = 1'b0; n.fin = 1'b1; end
                end
                OP_OUT: begin
                    if (q.ph == 2'd0) n.sk = 1'b1;
                    else if (q.ph == 2'd1) n.sk = 1'b0;
                    else begin
                        n.sh   = q.sh << 1;
                        n.left = q.left - 1'b1;
                        if (q.left == NB_W'(1)) begin
                            n.di   = 1'b0;
                            n.busy = 1'b0;
                            n.fin  = 1'b1;
                        end else begin
                            n.di = n.sh[SH_W-1];
                            n.ph = 2'd0;
                        end
                    end
                end
                OP_IN: begin
                    if (q.ph == 2'd0) begin
                        n.rx = {q.rx[WORD_W-2:0], do_i};
                        n.sk = 1'b0;
                    end else begin
                        n.left = q.left - 1'b1;
                        if (q.left == NB_W'(1)) begin
                            n.busy = 1'b0;
                            n.fin  = 1'b1;
                        end else begin
                            n.sk = 1'b1;
                            n.ph = 2'd0;
                        end
                    end
                end
                OP_STBY: begin
                    case (q.ph)
                        2'd0:    n.sk = 1'b1;
                        2'd1:    n.cs = 1'b1;
                        2'd2:    n.sk = 1'b0;
                        default: begin n.busy = 1'b0; n.fin = 1'b1; end
                    endcase
                end
                default: begin
                    if (q.ph == 2'd0) n.sk = 1'b1;
                    else if (q.ph == 2'd1) n.sk = 1'b0;
                    else begin n.busy = 1'b0; n.fin = 1'b1; end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign idle_o = !q.busy;
    assign fin_o  = q.fin;
    assign rx_o   = q.rx;
    assign cs_o   = q.cs;
    assign sk_o   = q.sk;
    assign di_o   = q.di;

    // R11
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sk |-> $stable(q.di));
endmodule

// File: rtl/mw_eeprom_master.sv
`timescale 1ns/1ps
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int OP_W     = 3,
    parameter int HOST_W   = 16,
    parameter int DLY      = 4,
    parameter int GAP_W    = 8,
    parameter int POLL_MAX = 200,
    parameter logic [OP_W-1:0] RD_OP   = 3'b110,
    parameter logic [OP_W-1:0] WR_OP   = 3'b101,
    parameter logic [OP_W+1:0] EWEN_OP = 5'b10011,
    parameter logic [OP_W+1:0] EWDS_OP = 5'b10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [HOST_W-1:0] offset_i,
    input  logic [HOST_W-1:0] count_i,
    input  logic [GAP_W-1:0]  poll_gap_i,
    input  logic [15:0]       wr_data_i,
    output logic              wr_take_o,
    output logic [15:0]       rd_data_o,
    output logic              rd_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    input  logic              ee_do_i
);
    localparam int WORD_W = 16;
    localparam int SH_W   = OP_W + ADDR_W + WORD_W;
    localparam int NB_W   = $clog2(SH_W + 1);
    localparam int TRY_W  = $clog2(POLL_MAX + 1);

    typedef struct packed {
        seq_e              st;
        logic              issued;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [HOST_W-1:0] left;
        logic [TRY_W-1:0]  tries;
        logic [GAP_W-1:0]  gap;
        logic              fail;
        logic              take;
        logic              rvalid;
        logic              done;
        logic              err;
    } seq_st_t;

    seq_st_t q, n;

    logic            req_ok, eng_idle, eng_fin, need, go, fin;
    wire_op_e        op;
    logic [SH_W-1:0] vec;
    logic [NB_W-1:0] nb;
    logic [WORD_W-1:0] eng_rx;

    mw_bounds #(.ADDR_W(ADDR_W), .HOST_W(HOST_W)) u_bounds (
        .offset_i(offset_i), .count_i(count_i), .ok_o(req_ok)
    );

    mw_wire #(.SH_W(SH_W), .DLY(DLY), .WORD_W(WORD_W), .NB_W(NB_W)) u_wire (
        .clk(clk), .rst_n(rst_n), .go_i(go), .op_i(op), .vec_i(vec),
        .nbits_i(nb), .idle_o(eng_idle), .fin_o(eng_fin), .rx_o(eng_rx),
        .cs_o(ee_cs_o), .sk_o(ee_sk_o), .di_o(ee_di_o), .do_i(ee_do_i)
    );

    always_comb begin
        n        = q;
        n.take   = 1'b0;
        n.rvalid = 1'b0;
        n.done   = 1'b0;
        n.err    = 1'b0;
        need     = 1'b0;
        op       = OP_PREP;
        vec      = '0;
        nb       = '0;
        fin      = q.issued && eng_fin;
        case (q.st)
            S_IDLE: if (start_i) begin
                if (req_ok) begin
                    n.st   = S_PREP;
                    n.wr   = write_i;
                    n.addr = offset_i[ADDR_W-1:0];
                    n.left = count_i;
                    n.fail = 1'b0;
                end else begin
                    n.err = 1'b1;
                end
            end
            S_PREP: begin
                need = 1'b1; op = OP_PREP;
                if (fin) begin n.issued = 1'b0; n.st = q.wr ? S_EWEN : S_CMD; end
            end
            S_EWEN: begin
                need = 1'b1; op = OP_OUT; nb = NB_W'(OP_W + ADDR_W);
                vec  = {EWEN_OP, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
                if (fin) begin n.issued = 1'b0; n.st = S_EN_SB; end
            end
            S_EN_SB: begin
                need = 1'b1; op = OP_STBY;
                if (fin) begin n.issued = 1'b0; n.st = S_CMD; end
            end
            S_CMD: begin
                need = 1'b1; op = OP_OUT;
                if (q.wr) begin
                    vec = {WR_OP, q.addr, wr_data_i};
                    nb  = NB_W'(SH_W);
                end else begin
                    vec = {RD_OP, q.addr, {WORD_W{1'b0}}};
                    nb  = NB_W'(OP_W + ADDR_W);
                end
                if (fin) begin n.issued = 1'b0; n.st = q.wr ? S_WR_SB : S_RDIN; end
            end
            S_RDIN: begin
                need = 1'b1; op = OP_IN; nb = NB_W'(WORD_W);
                if (fin) begin n.issued = 1'b0; n.rvalid = 1'b1; n.st = S_RD_SB; end
            end
            S_RD_SB: begin
                need = 1'b1; op = OP_STBY;
                if (fin) begin
                    n.issued = 1'b0;
                    n.addr   = q.addr + 1'b1;
                    n.left   = q.left - 1'b1;
                    n.st     = (q.left == HOST_W'(1)) ? S_STOP : S_CMD;
                end
            end
            S_WR_SB: begin
                need = 1'b1; op = OP_STBY;
                if (fin) begin n.issued = 1'b0; n.tries = '0; n.st = S_POLL; end
            end
            S_POLL: begin
                if (ee_do_i) n.st = S_WR_SB2;
                else if (q.tries == TRY_W'(POLL_MAX - 1)) begin
                    n.fail = 1'b1;
                    n.st   = S_STOP;
                end else begin
                    n.tries = q.tries + 1'b1;
                    n.gap   = poll_gap_i;
                    n.st    = S_GAP;
                end
            end
            S_GAP: begin
                if (q.gap == '0) n.st = S_POLL;
                else             n.gap = q.gap - 1'b1;
            end
            S_WR_SB2: begin
                need = 1'b1; op = OP_STBY;
                if (fin) begin
                    n.issued = 1'b0;
                    n.addr   = q.addr + 1'b1;
                    n.left   = q.left - 1'b1;
                    n.st     = (q.left == HOST_W'(1)) ? S_EWDS : S_CMD;
                end
            end
            S_EWDS: begin
                need = 1'b1; op = OP_OUT; nb = NB_W'(OP_W + ADDR_W);
                vec  = {EWDS_OP, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
                if (fin) begin n.issued = 1'b0; n.st = S_STOP; end
            end
            default: begin
                need = 1'b1; op = OP_STOP;
                if (fin) begin
                    n.issued = 1'b0;
                    n.st     = S_IDLE;
                    n.done   = !q.fail;
                    n.err    = q.fail;
                end
            end
        endcase
        go = need && !q.issued && eng_idle;
        if (go) n.issued = 1'b1;
        if (go && q.st == S_CMD && q.wr) n.take = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy_o     = (q.st != S_IDLE);
    assign wr_take_o  = q.take;
    assign rd_valid_o = q.rvalid;
    assign rd_data_o  = eng_rx;
    assign done_o     = q.done;
    assign err_o      = q.err;

    // R1
    bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && start_i && !req_ok) |=> err_o);
    // R5
    take_wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take_o |-> q.wr);
    // R6
    ready_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WR_SB2 && $past(q.st) == S_POLL) |-> $past(ee_do_i));
    // R7
    tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tries < TRY_W'(POLL_MAX));
    // R7
    err_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !ee_cs_o);
    // R9
    idle_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> !ee_cs_o);
    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));
endmodule

// File: tb/mw_eeprom_master_test.sv
`timescale 1ns/1ps
module mw_eeprom_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, write_i = 1'b0;
    logic [15:0] offset_i = '0, count_i = '0, wr_data_i = '0;
    logic [7:0]  poll_gap_i = 8'd2;
    logic        wr_take_o, rd_valid_o, busy_o, done_o, err_o;
    logic [15:0] rd_data_o;
    logic        ee_cs, ee_sk, ee_di;
    logic        do_r = 1'b1;

    always #2.5 clk = ~clk;

    mw_eeprom_master uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .offset_i(offset_i), .count_i(count_i), .poll_gap_i(poll_gap_i),
        .wr_data_i(wr_data_i), .wr_take_o(wr_take_o), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(do_r)
    );

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit finished = 0;

    // ---------------- device model ----------------
    logic [15:0] dev_mem [64];
    logic [15:0] shadow  [64];
    logic [31:0] cmd = '0;
    logic [5:0]  rd_addr = '0;
    logic        rd_bit = 1'b0, sk_p = 1'b0, cs_p = 1'b0, di_p = 1'b0;
    bit rd_mode = 0, we_en = 0, wr_pend = 0, stuck = 0;
    int bc = 0, rd_k = 0, busy_cnt = 0, busy_len = 0;
    int cs_rise = 0, di_viol = 0, early = 0, n_rd = 0, n_wr = 0;
    int n_ewen = 0, n_ewds = 0, bad_pad = 0, dropped = 0;

    function automatic logic [15:0] init_word(int i);
        return 16'hA5C3 ^ 16'(i * 16'h1357);
    endfunction

    function automatic bit req_ok(int ofs, int cnt);
        return (cnt != 0) && (ofs < 64) && (cnt <= 64 - ofs);
    endfunction

    always @(posedge clk) begin
        if (busy_cnt > 0) busy_cnt--;
        if (ee_cs && !cs_p) cs_rise++;
        if (!ee_cs && cs_p) begin
            bc = 0; rd_mode = 0; cmd = '0;
            if (wr_pend) begin busy_cnt = busy_len; wr_pend = 0; end
        end
        if (ee_sk && sk_p && ee_di != di_p) di_viol++;
        if (ee_cs && ee_sk && !sk_p) begin
            if (rd_mode) begin
                rd_bit = dev_mem[rd_addr][15-rd_k];
                rd_k++;
            end else begin
                if (bc == 0 && (busy_cnt > 0 || stuck)) early++;
                cmd = {cmd[30:0], ee_di};
                bc++;
                if (bc == 9) begin
                    if (cmd[8:6] == 3'b110) begin
                        rd_mode = 1; rd_addr = cmd[5:0]; rd_k = 0; n_rd++;
                    end else if (cmd[8:6] == 3'b100) begin
                        if (cmd[3:0] != 4'd0) bad_pad++;
                        if (cmd[5:4] == 2'b11) begin we_en = 1; n_ewen++; end
                        else if (cmd[5:4] == 2'b00) begin we_en = 0; n_ewds++; end
                        else bad_pad++;
                    end
                end
                if (bc == 25 && cmd[24:22] == 3'b101) begin
                    n_wr++;
                    if (we_en) dev_mem[cmd[21:16]] = cmd[15:0];
                    else dropped++;
                    wr_pend = 1;
                end
            end
        end
        sk_p = ee_sk; cs_p = ee_cs; di_p = ee_di;
        do_r <= rd_mode ? rd_bit : (busy_cnt == 0 && !stuck);
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            summary();
        end
    end

    int last_cyc;

    task automatic run_op(bit wr, int ofs, int cnt);
        logic [15:0] wv [64];
        int ti = 0, ri = 0, d_n = 0, e_n = 0, both = 0, takes = 0, cyc = 0, lag = 0;
        int rise0 = cs_rise, rd0 = n_rd, en0 = n_ewen, ds0 = n_ewds, ea0 = early;
        bit ok = req_ok(ofs, cnt);
        for (int i = 0; i < 64; i++) wv[i] = 16'($urandom);
        @(negedge clk);
        start_i = 1; write_i = wr; offset_i = 16'(ofs); count_i = 16'(cnt);
        wr_data_i = wv[0];
        forever begin
            @(negedge clk);
            start_i = 0; cyc++;
            if (wr_take_o) begin
                takes++; ti++;
                wr_data_i = (ti < 64) ? wv[ti] : 16'd0;
            end
            if (rd_valid_o) begin
                chk(rd_data_o == shadow[(ofs+ri)%64], "R2 read word",
                    int'(rd_data_o), int'(shadow[(ofs+ri)%64]));
                ri++;
            end
            if (done_o) d_n++;
            if (err_o) e_n++;
            if (done_o && err_o) both++;
            if (done_o || err_o) begin
                last_cyc = cyc;
                @(negedge clk);
                if (done_o || err_o) lag++;
                break;
            end
        end
        chk(both == 0 && lag == 0, "R10 single exclusive pulse", both + lag, 0);
        chk(!ee_cs && !ee_di && !busy_o, "R9 pins low after end",
            int'({ee_cs, ee_di, busy_o}), 0);
        if (!ok) begin
            chk(e_n == 1 && d_n == 0 && last_cyc == 1, "R1 reject timing",
                last_cyc, 1);
            chk(cs_rise == rise0, "R1 no chip select", cs_rise - rise0, 0);
        end else if (!wr) begin
            chk(d_n == 1 && e_n == 0, "R9 read done", d_n, 1);
            chk(ri == cnt && n_rd - rd0 == cnt, "R2 word count", ri, cnt);
            chk(cs_rise - rise0 == cnt + 1, "R3 read cs cycles", cs_rise - rise0, cnt + 1);
        end else if (!stuck) begin
            chk(d_n == 1 && e_n == 0, "R9 write done", d_n, 1);
            chk(takes == cnt, "R5 take pulses", takes, cnt);
            for (int i = 0; i < cnt; i++) begin
                chk(dev_mem[ofs+i] == wv[i], "R5 device word",
                    int'(dev_mem[ofs+i]), int'(wv[i]));
                shadow[ofs+i] = wv[i];
            end
            chk(n_ewen - en0 == 1 && bad_pad == 0, "R4 enable frame", n_ewen - en0, 1);
            chk(n_ewds - ds0 == 1 && !we_en, "R8 disable frame", n_ewds - ds0, 1);
            chk(cs_rise - rise0 == 2*cnt + 2, "R3 write cs cycles",
                cs_rise - rise0, 2*cnt + 2);
            chk(early == ea0, "R6 no command while busy", early - ea0, 0);
        end else begin
            chk(e_n == 1 && d_n == 0, "R7 timeout error", e_n, 1);
            chk(n_ewds == ds0 && we_en, "R7 no disable sent", n_ewds - ds0, 0);
            chk(last_cyc > 199 * (int'(poll_gap_i) + 2), "R7 poll span",
                last_cyc, 199 * (int'(poll_gap_i) + 2));
        end
    endtask

    initial begin
        int s, ofs, cnt, mx;
        s = int'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            dev_mem[i] = init_word(i);
            shadow[i]  = init_word(i);
        end
        repeat (4) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy_o, done_o, err_o} == 6'd0, "R9 reset state",
            int'({ee_cs, ee_sk, ee_di, busy_o, done_o, err_o}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // directed corners
        run_op(0, 64, 1);       // R1 offset at size
        run_op(1, 3, 0);        // R1 zero count
        run_op(0, 60, 5);       // R1 count past end
        run_op(0, 63, 1);       // R2 last word
        busy_len = 40;
        run_op(1, 62, 2);       // R5 top boundary write, R6 polling
        run_op(0, 61, 3);       // R2 read back
        busy_len = 0;
        run_op(1, 0, 1);        // R6 ready at first poll
        run_op(0, 0, 64);       // R3 whole device

        // randomized mix
        for (int k = 0; k < 18; k++) begin
            poll_gap_i = 8'($urandom_range(0, 7));
            busy_len = int'($urandom_range(0, 80));
            if ($urandom_range(0, 9) == 9) begin
                ofs = int'($urandom_range(0, 90));
                cnt = int'($urandom_range(0, 70));
            end else begin
                ofs = int'($urandom_range(0, 63));
                mx  = (64 - ofs < 4) ? 64 - ofs : 4;
                cnt = int'($urandom_range(1, mx));
            end
            run_op(1'($urandom_range(0, 1)), ofs, cnt);
        end

        // R7 device never ready
        poll_gap_i = 8'd3;
        stuck = 1;
        run_op(1, 10, 2);
        stuck = 0;
        shadow[10] = dev_mem[10];
        run_op(0, 10, 2);

        chk(di_viol == 0, "R11 DI steady while SK high", di_viol, 0);
        chk(dropped == 0, "R4 writes enabled", dropped, 0);
        summary();
    end
endmodule